// File: doc/BRIEF.md
# Conditional and Bit-Test Branch Resolver

This block decides, for one decoded branch instruction, whether the branch is taken and where execution continues. It handles two families. The first is the flag branches, which look at the carry, zero or negative flag. The second is the single-bit tests, which examine one bit of either the accumulator or a zero-page byte that has already been fetched. The bit number is carried in the opcode itself. Opcodes that step by 0x20 select bits 0 to 7.

The instruction fetch logic supplies the following already fetched:
- the opcode,
- the status flags,
- the accumulator,
- the memory byte,
- the signed 8-bit displacement,
- the address of the byte that follows the complete instruction.

The block returns four results:
- the taken decision,
- the next program address,
- the instruction length in bytes,
- a flag marking opcodes that are not branches.

With the default configuration the results are registered, so they appear one clock after the inputs are presented.

Top module: `brx_unit`

## Requirements
- R1: For the set-test opcodes, a low five bits of 0x03 tests the accumulator and 0x07 tests the memory byte. The branch is taken exactly when the selected bit is 1. The bit index is opcode bits 7:5, and opcode bit 2 selects memory (1) over the accumulator (0).
- R2: For the clear-test opcodes, a low five bits of 0x13 tests the accumulator and 0x17 tests the memory byte. The branch is taken exactly when the selected bit is 0. Bit index and source are chosen as in R1.
- R3: `ins_len` reports 2 for a bit test on the accumulator, 3 for a bit test on the memory byte, and 2 for every flag branch.
- R4: The flag branches are decided from `st_flags`, where bit 7 is N, bit 1 is Z and bit 0 is C:
  - 0x90 is taken when C=0.
  - 0xB0 is taken when C=1.
  - 0xF0 is taken when Z=1.
  - 0xD0 is taken when Z=0.
  - 0x30 is taken when N=1.
  - Flag bits 6 down to 2 have no effect.
- R5: When the branch is taken, `target` equals `insn_end` plus the sign-extended `disp`, modulo 2^16.
- R6: When a valid branch is not taken, `target` equals `insn_end`.
- R7: Any other opcode gives `invalid`=1, `taken`=0 and `ins_len`=0.
- R8: The outputs reflect the inputs from the previous clock. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 8 | Instruction opcode |
| st_flags | input | 8 | Status flags (N=7, Z=1, C=0) |
| acc | input | 8 | Accumulator value |
| mem_byte | input | 8 | Fetched zero-page byte |
| disp | input | 8 | Signed relative displacement |
| insn_end | input | 16 | Address following the complete instruction |
| taken | output | 1 | Branch taken |
| target | output | 16 | Next program address |
| ins_len | output | 2 | Instruction length in bytes |
| invalid | output | 1 | Opcode is not a branch |

## Verification
The hardest case to reach is the combination of each of the eight bit indices with each operand source and each test polarity, together with a displacement that carries across the 16-bit address wrap. Random opcodes hit the 32 bit-test encodings only rarely. The stimulus therefore sweeps all 256 opcodes against 256 operand values each. The accumulator, memory byte, flags and displacement are each a bijective function of the sweep index, so every bit value, flag combination and displacement sign is reached for every opcode. Base addresses near 0xFFFF are included so that the sum wraps.

// File: rtl/brx_pkg.sv
package brx_pkg;
   localparam int IDX_W = 3;
   localparam int LEN_W = 2;
   localparam int FLG_N = 7;
   localparam int FLG_Z = 1;
   localparam int FLG_C = 0;

   typedef enum logic [1:0] {BK_NONE, BK_FLAG, BK_BIT} br_kind_e;
   typedef enum logic [2:0] {FC_CC, FC_CS, FC_EQ, FC_NE, FC_MI} flag_cond_e;

   typedef struct packed {
      br_kind_e           kind;
      logic               want_set;
      logic               from_mem;
      logic [IDX_W-1:0]   bit_idx;
      flag_cond_e         fcond;
      logic [LEN_W-1:0]   len;
   } brx_dec_t;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
   import brx_pkg::*;
(
   input  logic [7:0] opcode,
   output brx_dec_t   dec
);
   logic is_bit;
   assign is_bit = (opcode[1:0] == 2'b11) && (opcode[3] == 1'b0);

   always_comb begin
      dec          = '0;
      dec.kind     = BK_NONE;
      dec.fcond    = FC_CC;
      dec.bit_idx  = opcode[7:5];
      dec.from_mem = opcode[2];
      if (is_bit) begin
         dec.kind     = BK_BIT;
         dec.want_set = ~opcode[4];
         dec.len      = opcode[2] ? LEN_W'(3) : LEN_W'(2);
      end else begin
         unique case (opcode)
            8'h90: begin dec.kind = BK_FLAG; dec.fcond = FC_CC; end
            8'hB0: begin dec.kind = BK_FLAG; dec.fcond = FC_CS; end
            8'hF0: begin dec.kind = BK_FLAG; dec.fcond = FC_EQ; end
            8'hD0: begin dec.kind = BK_FLAG; dec.fcond = FC_NE; end
            8'h30: begin dec.kind = BK_FLAG; dec.fcond = FC_MI; end
            default: dec.kind = BK_NONE;
         endcase
         if (dec.kind == BK_FLAG) dec.len = LEN_W'(2);
      end
   end
endmodule

// File: rtl/brx_cond.sv
module brx_cond
   import brx_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  brx_dec_t          dec,
   input  logic [7:0]        st_flags,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] mem_byte,
   output logic              taken_c,
   output logic              invalid_c
);
   logic [DATA_W-1:0] operand;
   logic              sel_bit;
   logic              flag_hit;

   assign operand = dec.from_mem ? mem_byte : acc;

   // bit selector built as an explicit one-hot mux
   logic [DATA_W-1:0] hit_vec;
   for (genvar g = 0; g < DATA_W; g++) begin : g_sel
      assign hit_vec[g] = operand[g] & (dec.bit_idx == IDX_W'(g));
   end
   assign sel_bit = |hit_vec;

   always_comb begin
      unique case (dec.fcond)
         FC_CC:   flag_hit = ~st_flags[FLG_C];
         FC_CS:   flag_hit =  st_flags[FLG_C];
         FC_EQ:   flag_hit =  st_flags[FLG_Z];
         FC_NE:   flag_hit = ~st_flags[FLG_Z];
         FC_MI:   flag_hit =  st_flags[FLG_N];
         default: flag_hit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (dec.kind)
         BK_BIT:  taken_c = (sel_bit == dec.want_set);
         BK_FLAG: taken_c = flag_hit;
         default: taken_c = 1'b0;
      endcase
   end
   assign invalid_c = (dec.kind == BK_NONE);
endmodule

// File: rtl/brx_target.sv
module brx_target #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8
)(
   input  logic [ADDR_W-1:0] insn_end,
   input  logic [DISP_W-1:0] disp,
   input  logic              take,
   output logic [ADDR_W-1:0] next_addr
);
   localparam int EXT_W = ADDR_W - DISP_W;
   logic [ADDR_W-1:0] disp_ext;
   assign disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign next_addr = take ? (insn_end + disp_ext) : insn_end;
endmodule

// File: rtl/brx_unit.sv
module brx_unit
   import brx_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int DISP_W  = 8,
   parameter bit OUT_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        opcode,
   input  logic [7:0]        st_flags,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] mem_byte,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] insn_end,
   output logic              taken,
   output logic [ADDR_W-1:0] target,
   output logic [LEN_W-1:0]  ins_len,
   output logic              invalid
);
   if (DATA_W != (1 << IDX_W)) begin : g_chk_data
      $error("brx_unit: DATA_W must equal 2**IDX_W");
   end
   if (ADDR_W <= DISP_W) begin : g_chk_addr
      $error("brx_unit: ADDR_W must exceed DISP_W");
   end

   brx_dec_t          dec;
   logic              taken_c, invalid_c;
   logic [ADDR_W-1:0] next_c;

   brx_decode u_dec (.opcode(opcode), .dec(dec));

   brx_cond #(.DATA_W(DATA_W)) u_cond (
      .dec(dec), .st_flags(st_flags), .acc(acc), .mem_byte(mem_byte),
      .taken_c(taken_c), .invalid_c(invalid_c));

   brx_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
      .insn_end(insn_end), .disp(disp), .take(taken_c), .next_addr(next_c));

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            taken   <= 1'b0;
            target  <= '0;
            ins_len <= '0;
            invalid <= 1'b0;
         end else begin
            taken   <= taken_c;
            target  <= next_c;
            ins_len <= dec.len;
            invalid <= invalid_c;
         end
      end
   end else begin : g_comb
      assign taken   = taken_c;
      assign target  = next_c;
      assign ins_len = dec.len;
      assign invalid = invalid_c;
   end
endmodule

// File: rtl/brx_unit_chk.sv
module brx_unit_chk #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int DISP_W  = 8,
   parameter bit OUT_REG = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        opcode,
   input logic [7:0]        st_flags,
   input logic [DATA_W-1:0] acc,
   input logic [DATA_W-1:0] mem_byte,
   input logic [DISP_W-1:0] disp,
   input logic [ADDR_W-1:0] insn_end,
   input logic              taken,
   input logic [ADDR_W-1:0] target,
   input logic [1:0]        ins_len,
   input logic              invalid
);
   AST_INVALID_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> !taken); // R7

   if (OUT_REG) begin : g_seq
      AST_BBS_ACC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
         (opcode[4:0] == 5'h03 && acc[opcode[7:5]]) |=> taken); // R1
      AST_BBC_MEM_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
         (opcode[4:0] == 5'h17 && !mem_byte[opcode[7:5]]) |=> taken); // R2
      AST_MEM_TEST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
         (opcode[4:0] == 5'h07) |=> (ins_len == 2'd3)); // R3
      AST_CARRY_CLEAR_BR: assert property (@(posedge clk) disable iff (!rst_n)
         (opcode == 8'h90) |=> (taken == !$past(st_flags[0]))); // R4
      AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (!taken || target == ADDR_W'($past(insn_end)
            + {{(ADDR_W-DISP_W){$past(disp[DISP_W-1])}}, $past(disp)}))); // R5
      AST_FALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (taken || invalid || target == $past(insn_end))); // R6
      AST_RESET_CLEAR: assert property (@(posedge clk)
         !rst_n |=> (!taken && !invalid && ins_len == 2'd0)); // R8
   end
endmodule

bind brx_unit brx_unit_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .opcode(opcode), .st_flags(st_flags),
   .acc(acc), .mem_byte(mem_byte), .disp(disp), .insn_end(insn_end),
   .taken(taken), .target(target), .ins_len(ins_len), .invalid(invalid)
);

// File: tb/sim_brx_unit.sv
`timescale 1ns/1ps
module sim_brx_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  opcode = '0, st_flags = '0, acc = '0, mem_byte = '0, disp = '0;
   logic [15:0] insn_end = '0;
   logic        taken, invalid;
   logic [15:0] target;
   logic [1:0]  ins_len;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   brx_unit u0 (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .st_flags(st_flags),
      .acc(acc), .mem_byte(mem_byte), .disp(disp), .insn_end(insn_end),
      .taken(taken), .target(target), .ins_len(ins_len), .invalid(invalid));

   task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      // R8: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset", {taken, invalid, ins_len, target}, 20'h0);
      rst_n = 1'b1;
      for (int op = 0; op < 256; op++) begin
         for (int v = 0; v < 256; v++) begin
            logic [7:0]  o, a, m, f, d;
            logic [15:0] e, tg;
            logic        t, inv;
            logic [1:0]  ln;
            logic [2:0]  ix;
            string       rq;
            o = 8'(op); a = 8'(v); m = 8'(v * 7 + 3);
            f = 8'(v * 13); d = 8'(v * 29 + 1);
            e = 16'(op * 251 + v * 1031 + 16'hFF00);
            ix = o[7:5]; inv = 1'b0;
            case (o[4:0])
               5'h03: begin t =  a[ix]; ln = 2'd2; rq = "R1/R3 set-acc"; end
               5'h07: begin t =  m[ix]; ln = 2'd3; rq = "R1/R3 set-mem"; end
               5'h13: begin t = !a[ix]; ln = 2'd2; rq = "R2/R3 clr-acc"; end
               5'h17: begin t = !m[ix]; ln = 2'd3; rq = "R2/R3 clr-mem"; end
               default: begin
                  ln = 2'd2; rq = "R4 flag";
                  case (o)
                     8'h90: t = !f[0];
                     8'hB0: t =  f[0];
                     8'hF0: t =  f[1];
                     8'hD0: t = !f[1];
                     8'h30: t =  f[7];
                     default: begin t = 1'b0; ln = 2'd0; inv = 1'b1; rq = "R7 invalid"; end
                  endcase
               end
            endcase
            tg = t ? 16'(e + {{8{d[7]}}, d}) : e;
            opcode = o; acc = a; mem_byte = m; st_flags = f; disp = d; insn_end = e;
            @(posedge clk);
            @(negedge clk);
            check(rq, {16'h0, taken, invalid, ins_len}, {16'h0, t, inv, ln});
            if (!inv) check(t ? "R5 taken target" : "R6 fall target", {4'h0, target}, {4'h0, tg});
         end
      end
      // R8: reset clears outputs after activity
      opcode = 8'h03; acc = 8'h01; @(posedge clk); @(negedge clk);
      check("R8 pre-reset taken", {19'h0, taken}, 20'h1);
      rst_n = 1'b0; @(posedge clk); @(negedge clk);
      check("R8 reset clear", {taken, invalid, ins_len, target}, 20'h0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule